// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This unit sits next to a processor pipeline and watches three streams every cycle: the instruction-fetch address, the load/store address and the load/store data. Each stream has its own valid strobe. Eight programmable comparators are fixed to the streams. Four watch the fetch address, two watch the load/store address and two watch the load/store data. Each comparator tests its operand against a stored value with one of four conditions.

Comparator hits are merged into six watchpoint events, which appear on registered output pins. Adjacent comparators can be paired to match an address window. The two data comparators can qualify the load/store address watchpoints. Four breakpoint channels each pick one watchpoint and count it down from a loaded value. A channel raises its breakpoint request when its count reaches zero and holds it until software writes the channel again.

Software programs the unit through a simple write port. Addresses 0–7 hold the comparator values. Addresses 8–15 hold the comparator controls. Address 16 holds the pairing and qualify bits. Addresses 20–23 hold breakpoint channels 0–3.

Top module: `dbg_watch_unit`

## Requirements
- R1: Comparator control word (address 8+i): bits[1:0] select the condition (0 equal, 1 not equal, 2 operand less than value, 3 operand greater than value), and bit 2 enables the comparator. Less-than and greater-than are unsigned.
- R2: Comparators 0–3 examine the fetch address, 4–5 the load/store address, and 6–7 the load/store data. A comparator never reacts to another stream.
- R3: A comparator reports a hit only in a cycle where its stream's valid strobe is high.
- R4: Watchpoint pins 0–3 follow comparators 0–3, and pins 4–5 follow comparators 4–5. Each pin is high in the cycle after the edge that samples the matching input.
- R5: Pairing bits at address 16: bit0 makes pin 0 the AND of comparators 0 and 1, bit1 makes pin 2 the AND of comparators 2 and 3, and bit2 makes pin 4 the AND of comparators 4 and 5.
- R6: Qualify bits at address 16: bit3 additionally requires comparator 6 for pin 4, and bit4 additionally requires comparator 7 for pin 5.
- R7: A breakpoint channel write (address 20+n) loads the count from bits[CNT_W-1:0] and the source pin from bits[18:16]. Each cycle in which the selected pin is high, the count drops by one. When the count reaches zero, brk_req[n] rises one cycle after the pin event that did it.
- R8: Once raised, a breakpoint request stays high, and further events do not change it, until the channel is written again.
- R9: Writing a count of zero disarms a channel, and its request then stays low whatever events occur.
- R10: A disabled comparator never hits.
- R11: After reset all comparators are disabled, all pins and requests are low, and all channels are disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifetch_vld | input | 1 | Fetch address valid |
| ifetch_addr | input | AW | Fetch effective address |
| ls_vld | input | 1 | Load/store valid |
| ls_addr | input | AW | Load/store effective address |
| ls_data | input | DW | Load/store data value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| wp_pins | output | 6 | Registered watchpoint events |
| brk_req | output | NBRK | Breakpoint requests, one per channel |

## Verification
A watchpoint pin is due in the cycle right after the clock edge that samples a valid input. The bench drives each input on a falling edge, waits one rising edge, and reads the pins at the next falling edge. Breakpoint requests are one more register stage back, so after each event the bench waits one further rising edge before it reads brk_req. A configuration write takes effect at its own rising edge, so the bench issues stimulus only after that edge. The main sweep covers every 8-bit fetch address under each of the four conditions.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GT = 2'd3
  } cmp_cond_e;

  localparam int NUM_IF_CMP = 4;
  localparam int NUM_LA_CMP = 2;
  localparam int NUM_LD_CMP = 2;
  localparam int NUM_CMP    = NUM_IF_CMP + NUM_LA_CMP + NUM_LD_CMP;
  localparam int NUM_WP     = 6;
  localparam int SRC_W      = 3;
  localparam int SRC_LSB    = 16;
  localparam int CFG_W      = 32;
  localparam int CFG_AW     = 5;
  localparam logic [CFG_AW-1:0] ADDR_CTL_BASE = 5'd8;
  localparam logic [CFG_AW-1:0] ADDR_MODE     = 5'd16;
  localparam logic [CFG_AW-1:0] ADDR_BRK_BASE = 5'd20;
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
  import dbg_watch_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_val,
  input  logic         wr_ctl,
  input  logic [W-1:0] wval,
  input  logic [2:0]   wctl,
  input  logic         vld,
  input  logic [W-1:0] operand,
  output logic         hit
);
  logic [W-1:0] ref_q;
  cmp_cond_e    cond_q;
  logic         en_q;
  logic         match;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      cond_q <= CMP_EQ;
      en_q   <= 1'b0;
    end else begin
      if (wr_val) ref_q <= wval;
      if (wr_ctl) begin
        cond_q <= cmp_cond_e'(wctl[1:0]);
        en_q   <= wctl[2];
      end
    end
  end

  always_comb begin
    unique case (cond_q)
      CMP_EQ:  match = (operand == ref_q);
      CMP_NE:  match = (operand != ref_q);
      CMP_LT:  match = (operand <  ref_q);
      default: match = (operand >  ref_q);
    endcase
  end

  assign hit = en_q & vld & match;
endmodule

// File: rtl/dbg_brk_cnt.sv
module dbg_brk_cnt
  import dbg_watch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [SRC_W-1:0] load_src,
  input  logic [NUM_WP-1:0] wp_vec,
  output logic             brk
);
  localparam int PADW = 1 << SRC_W;

  logic [SRC_W-1:0] src_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [PADW-1:0]  wp_pad;
  logic             evt;

  assign wp_pad = PADW'(wp_vec);
  assign evt    = wp_pad[src_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '1;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      src_q   <= load_src;
      cnt_q   <= load_cnt;
      armed_q <= (load_cnt != '0);
    end else if (armed_q && cnt_q != '0 && evt) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign brk = armed_q & (cnt_q == '0);
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int NBRK  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ifetch_vld,
  input  logic [AW-1:0]     ifetch_addr,
  input  logic              ls_vld,
  input  logic [AW-1:0]     ls_addr,
  input  logic [DW-1:0]     ls_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [NUM_WP-1:0] wp_pins,
  output logic [NBRK-1:0]   brk_req
);
  localparam int LA_BASE = NUM_IF_CMP;
  localparam int LD_BASE = NUM_IF_CMP + NUM_LA_CMP;

  logic [NUM_CMP-1:0] h;
  logic [NUM_CMP-1:0] wr_val, wr_ctl;
  logic [4:0]         mode_q;
  logic [NUM_WP-1:0]  wp_d, wp_q;
  logic               la_pair;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_dec
    assign wr_val[i] = cfg_we && (cfg_addr == CFG_AW'(i));
    assign wr_ctl[i] = cfg_we && (cfg_addr == ADDR_CTL_BASE + CFG_AW'(i));
  end

  for (genvar i = 0; i < NUM_IF_CMP; i++) begin : g_if
    dbg_cmp #(.W(AW)) u_cmp (
      .clk, .rst, .wr_val(wr_val[i]), .wr_ctl(wr_ctl[i]),
      .wval(cfg_wdata[AW-1:0]), .wctl(cfg_wdata[2:0]),
      .vld(ifetch_vld), .operand(ifetch_addr), .hit(h[i]));
  end
  for (genvar i = LA_BASE; i < LD_BASE; i++) begin : g_la
    dbg_cmp #(.W(AW)) u_cmp (
      .clk, .rst, .wr_val(wr_val[i]), .wr_ctl(wr_ctl[i]),
      .wval(cfg_wdata[AW-1:0]), .wctl(cfg_wdata[2:0]),
      .vld(ls_vld), .operand(ls_addr), .hit(h[i]));
  end
  for (genvar i = LD_BASE; i < NUM_CMP; i++) begin : g_ld
    dbg_cmp #(.W(DW)) u_cmp (
      .clk, .rst, .wr_val(wr_val[i]), .wr_ctl(wr_ctl[i]),
      .wval(cfg_wdata[DW-1:0]), .wctl(cfg_wdata[2:0]),
      .vld(ls_vld), .operand(ls_data), .hit(h[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)                                mode_q <= '0;
    else if (cfg_we && cfg_addr == ADDR_MODE) mode_q <= cfg_wdata[4:0];
  end

  always_comb begin
    wp_d[0] = mode_q[0] ? (h[0] & h[1]) : h[0];
    wp_d[1] = h[1];
    wp_d[2] = mode_q[1] ? (h[2] & h[3]) : h[2];
    wp_d[3] = h[3];
    la_pair = mode_q[2] ? (h[4] & h[5]) : h[4];
    wp_d[4] = la_pair & (mode_q[3] ? h[6] : 1'b1);
    wp_d[5] = h[5] & (mode_q[4] ? h[7] : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) wp_q <= '0;
    else     wp_q <= wp_d;
  end
  assign wp_pins = wp_q;

  for (genvar n = 0; n < NBRK; n++) begin : g_brk
    dbg_brk_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk, .rst,
      .load(cfg_we && cfg_addr == ADDR_BRK_BASE + CFG_AW'(n)),
      .load_cnt(cfg_wdata[CNT_W-1:0]),
      .load_src(cfg_wdata[SRC_LSB+SRC_W-1:SRC_LSB]),
      .wp_vec(wp_q), .brk(brk_req[n]));
  end
endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
  parameter int NBRK = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ifetch_vld,
  input logic            ls_vld,
  input logic            cfg_we,
  input logic [5:0]      wp_pins,
  input logic [NBRK-1:0] brk_req
);
  // R3
  fetch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ifetch_vld |=> wp_pins[3:0] == 4'b0);
  // R3
  ls_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ls_vld |=> wp_pins[5:4] == 2'b0);
  // R8
  brk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && brk_req != '0) |=> ((brk_req & $past(brk_req)) == $past(brk_req)));
  // R7
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ((brk_req & ~$past(brk_req)) != '0) |-> ($past(wp_pins) != '0));
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (wp_pins == '0 && brk_req == '0));
endmodule

bind dbg_watch_unit dbg_watch_chk #(.NBRK(NBRK)) u_chk (
  .clk(clk), .rst(rst), .ifetch_vld(ifetch_vld), .ls_vld(ls_vld),
  .cfg_we(cfg_we), .wp_pins(wp_pins), .brk_req(brk_req));

// File: tb/dbg_watch_unit_tb.sv
module dbg_watch_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CNT_W = 4;
  localparam int NBRK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ifetch_vld = 1'b0, ls_vld = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] ifetch_addr = '0, ls_addr = '0;
  logic [DW-1:0] ls_data = '0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  wp_pins;
  logic [NBRK-1:0] brk_req;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_watch_unit #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .NBRK(NBRK)) u_dut (
    .clk, .rst, .ifetch_vld, .ifetch_addr, .ls_vld, .ls_addr, .ls_data,
    .cfg_we, .cfg_addr, .cfg_wdata, .wp_pins, .brk_req);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int a, int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'(d);
    @(posedge clk); @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fetch(int a);
    @(negedge clk); ifetch_vld = 1'b1; ifetch_addr = AW'(a);
    @(posedge clk); @(negedge clk); ifetch_vld = 1'b0;
  endtask

  task automatic lsop(int a, int d, bit v = 1'b1);
    @(negedge clk); ls_vld = v; ls_addr = AW'(a); ls_data = DW'(d);
    @(posedge clk); @(negedge clk); ls_vld = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit ref_cmp(int c, int a, int v);
    case (c)
      0: return a == v;
      1: return a != v;
      2: return a < v;
      default: return a > v;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R11 reset state
    chk("R11 pins", int'(wp_pins), 0);
    chk("R11 brk", int'(brk_req), 0);
    fetch(8'h00);
    chk("R11 disabled after reset", int'(wp_pins), 0);

    // R1 sweep: comparator 0, every address, every condition, unsigned
    cfg(0, 8'h80);
    for (int c = 0; c < 4; c++) begin
      cfg(8, 4 | c);
      for (int a = 0; a < 256; a++) begin
        fetch(a);
        chk("R1 R4 cond sweep", int'(wp_pins[0]), int'(ref_cmp(c, a, 8'h80)));
      end
    end
    // R3 valid low gives no hit
    cfg(8, 4 | 1);
    @(negedge clk); ifetch_addr = 8'h11; settle();
    chk("R3 fetch valid low", int'(wp_pins[0]), 0);

    // R10 disabled comparator 2 never hits
    cfg(2, 8'h11); cfg(10, 3'b000);
    fetch(8'h11);
    chk("R10 disabled", int'(wp_pins[2]), 0);
    cfg(10, 3'b100);
    fetch(8'h11);
    chk("R10 enabled", int'(wp_pins[2]), 1);
    cfg(10, 3'b000);

    // R5 range on pin 0: >10 and <20
    cfg(0, 10); cfg(8, 4 | 3); cfg(1, 20); cfg(9, 4 | 2); cfg(16, 5'b00001);
    for (int a = 8; a < 23; a++) begin
      fetch(a);
      chk("R5 range", int'(wp_pins[0]), int'(a > 10 && a < 20));
    end
    cfg(16, 0); cfg(8, 0); cfg(9, 0);

    // R2 load/store comparator ignores fetch stream
    cfg(4, 8'h20); cfg(12, 4 | 0);
    fetch(8'h20);
    chk("R2 fetch ignored by ls cmp", int'(wp_pins[4]), 0);
    lsop(8'h20, 8'h00);
    chk("R2 R4 ls addr", int'(wp_pins[4]), 1);
    lsop(8'h20, 8'h00, 1'b0);
    chk("R3 ls valid low", int'(wp_pins[4]), 0);

    // R6 data qualifier on pin 4
    cfg(6, 8'h55); cfg(14, 4 | 0); cfg(16, 5'b01000);
    lsop(8'h20, 8'h55);
    chk("R6 qual match", int'(wp_pins[4]), 1);
    lsop(8'h20, 8'h54);
    chk("R6 qual miss", int'(wp_pins[4]), 0);
    lsop(8'h55, 8'h55);
    chk("R2 data cmp not on addr", int'(wp_pins[4]), 0);
    cfg(16, 0);

    // R7 count of 3 on pin 4 via channel 0
    cfg(20, (4 << 16) | 3);
    for (int k = 1; k <= 3; k++) begin
      lsop(8'h20, 0);
      settle();
      chk("R7 count down", int'(brk_req[0]), int'(k == 3));
    end
    chk("R7 other channels", int'(brk_req[3:1]), 0);
    // R8 hold under further events
    lsop(8'h20, 0); settle();
    chk("R8 hold", int'(brk_req[0]), 1);
    repeat (3) settle();
    chk("R8 hold idle", int'(brk_req[0]), 1);
    // R8 reload clears
    cfg(20, (4 << 16) | 1);
    chk("R8 reload clears", int'(brk_req[0]), 0);
    lsop(8'h20, 0); settle();
    chk("R7 count one", int'(brk_req[0]), 1);
    // R9 zero disarms
    cfg(20, (4 << 16) | 0);
    chk("R9 disarm", int'(brk_req[0]), 0);
    lsop(8'h20, 0); settle();
    lsop(8'h20, 0); settle();
    chk("R9 stays low", int'(brk_req[0]), 0);
    // R7 source select: channel 3 on pin 5, pin 4 events do not count
    cfg(5, 8'h30); cfg(13, 4 | 0);
    cfg(23, (5 << 16) | 1);
    lsop(8'h20, 0); settle();
    chk("R7 wrong source", int'(brk_req[3]), 0);
    lsop(8'h30, 0); settle();
    chk("R7 source pin5", int'(brk_req[3]), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule